// File: doc/BRIEF.md
# SDRAM Bank Timing and Refresh Tracker

This controller-side block follows the state of each bank of an SDRAM device: whether a row is open, and how long ago it was activated or precharged. A scheduler presents one decoded command per clock together with a bank number. The block answers with per-bank flags that say which commands may legally be issued on the next clock. Commands that break a timing rule are refused: they do not change any bank state, and they set a sticky protocol-error flag.

All minimum delays are given as parameters in picoseconds. They are turned into clock counts by dividing by the clock period parameter and rounding up. With the default period of 3750 ps, the row-to-column delay of 15 ns becomes 4 cycles, the precharge recovery of 15 ns becomes 4 cycles, and the row-cycle time of 55 ns becomes 15 cycles.

A refresh pacer counts clocks and adds one owed refresh each time an interval ends. The interval is 7.8 us by default. While the hot input is high it is 3.9 us, for case temperatures between 85 and 95 degrees C. A refresh request stays up as long as any refresh is owed. Each accepted refresh command pays one of them back.

Top module: `bank_tracker`

## Requirements
- R1: There are four banks, each tracked on its own. A legal activate (cmd_i=1) opens the addressed bank and a precharge (cmd_i=4) closes it, so bank_open_o shows the change after that clock edge. A precharge to a closed bank changes nothing. Codes 0, 6 and 7 are no-ops.
- R2: After a legal activate at edge t, rw_ok_o for that bank is low until edge t+TRCD_CYC-1 and high from then on while the bank stays open. TRCD_CYC is ceil(TRCD_PS/CLK_PS), which is 4 at the defaults. Read is cmd_i=2 and write is cmd_i=3.
- R3: After a precharge of an open bank at edge t, act_ok_o for that bank stays low until TRP_CYC cycles have passed. TRP_CYC is ceil(TRP_PS/CLK_PS), which is 4 at the defaults.
- R4: After an activate at edge t, a new activate to the same bank is not allowed before edge t+TRC_CYC. TRC_CYC is ceil(TRC_PS/CLK_PS), which is 15 at the defaults. act_ok_o is also low whenever the bank is open.
- R5: An activate while act_ok_o is low, a read or write while rw_ok_o is low, or a refresh while ref_ok_o is low sets proto_err_o. The flag stays set until reset, and the refused command leaves every bank and the refresh count unchanged.
- R6: ref_ok_o is high only when all banks are closed and all precharge recovery times have expired. A refresh is cmd_i=5.
- R7: ref_pending_o goes up by one at the end of every interval. The interval is ceil(REFI_PS/CLK_PS) cycles while hot_i is low and ceil(REFI_HOT_PS/CLK_PS) cycles while hot_i is high. The first interval ends on the interval-th edge after reset.
- R8: An accepted refresh lowers ref_pending_o by one, unless it is already zero. If an interval ends on the same edge, the count stays the same. ref_req_o is high exactly when ref_pending_o is nonzero.
- R9: ref_overdue_o is high when ref_pending_o has reached MAX_PEND (8). The count never goes above MAX_PEND.
- R10: After reset, all banks are closed, every act_ok_o bit is high, rw_ok_o is zero, ref_ok_o is high, the refresh count is zero, and proto_err_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh |
| bank_i | input | 2 | Bank addressed by cmd_i |
| hot_i | input | 1 | High selects the short refresh interval |
| bank_open_o | output | 4 | One bit per bank, high while a row is open |
| act_ok_o | output | 4 | Per bank, an activate is legal on the next edge |
| rw_ok_o | output | 4 | Per bank, a read or write is legal on the next edge |
| ref_ok_o | output | 1 | A refresh is legal on the next edge |
| ref_req_o | output | 1 | At least one refresh is owed |
| ref_overdue_o | output | 1 | The owed count has reached its limit |
| ref_pending_o | output | 4 | Number of owed refreshes |
| proto_err_o | output | 1 | Sticky: an illegal command was presented |

## Verification
A wrong bank counter shows up on act_ok_o or rw_ok_o on the exact cycle the delay should have ended. This is one cycle early or late, not a drift, so the bench compares every flag of every bank after every edge against a model built from the cycle counts above. A wrong refresh timer or count changes ref_pending_o on a specific edge, and errors in the pacer build up over many intervals. For that reason the bench shortens the intervals to 40 and 20 cycles and runs through saturation. A refused command that still changes state is exposed by the next flags of the bank it addressed, and an error flag that is not sticky is caught on the following cycle.

// File: rtl/bank_tracker_pkg.sv
package bank_tracker_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  // round a span up to whole clocks
  function automatic int ps_to_cyc(input int span_ps, input int clk_ps);
    return (span_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/delay_count.sv
module delay_count #(
  parameter int CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int W = (CYC > 1) ? $clog2(CYC) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= W'(CYC - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_load_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && CYC > 1) |=> !done_o);

  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && done_o) |=> done_o);

endmodule

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int TRCD_CYC = 4,
  parameter int TRP_CYC  = 4,
  parameter int TRC_CYC  = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic pre_i,
  output logic open_o,
  output logic act_ok_o,
  output logic rw_ok_o,
  output logic idle_o
);
  logic open_q;
  logic rcd_done, rp_done, rc_done;
  logic close_go;

  assign close_go = pre_i && open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       open_q <= 1'b0;
    else if (act_i)    open_q <= 1'b1;
    else if (close_go) open_q <= 1'b0;
  end

  delay_count #(.CYC(TRCD_CYC)) u_rcd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i), .done_o(rcd_done));
  delay_count #(.CYC(TRC_CYC)) u_rc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i), .done_o(rc_done));
  delay_count #(.CYC(TRP_CYC)) u_rp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(close_go), .done_o(rp_done));

  assign open_o   = open_q;
  assign act_ok_o = !open_q && rp_done && rc_done;
  assign rw_ok_o  = open_q && rcd_done;
  assign idle_o   = !open_q && rp_done;

  p_act_opens_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (open_o && !act_ok_o));

  p_pre_closes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !act_i) |=> !open_o);

  p_act_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_o);

  p_rw_after_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rw_ok_o) |-> $past(open_o));

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer #(
  parameter int NORM_CYC = 2080,
  parameter int HOT_CYC  = 1040,
  parameter int MAX_PEND = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            hot_i,
  input  logic                            ref_go_i,
  output logic [$clog2(MAX_PEND+1)-1:0]   pend_o,
  output logic                            req_o,
  output logic                            overdue_o
);
  localparam int TMAX = (NORM_CYC > HOT_CYC) ? NORM_CYC : HOT_CYC;
  localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1;
  localparam int PW   = $clog2(MAX_PEND + 1);

  logic [TW-1:0] tmr_q;
  logic [TW-1:0] lim;
  logic          tick;
  logic          pay;
  logic [PW-1:0] pend_q, pend_d;

  assign lim  = hot_i ? TW'(HOT_CYC - 1) : TW'(NORM_CYC - 1);
  assign tick = (tmr_q >= lim);
  assign pay  = ref_go_i && (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tmr_q <= '0;
    else if (tick) tmr_q <= '0;
    else           tmr_q <= tmr_q + 1'b1;
  end

  always_comb begin
    pend_d = pend_q;
    if (tick && !pay) begin
      if (pend_q != PW'(MAX_PEND)) pend_d = pend_q + 1'b1;
    end else if (!tick && pay) begin
      pend_d = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o    = pend_q;
  assign req_o     = (pend_q != '0);
  assign overdue_o = (pend_q >= PW'(MAX_PEND));

  p_pend_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o <= PW'(MAX_PEND));

  p_pend_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pend_o) |-> (pend_o == $past(pend_o) + 1'b1 || pend_o == $past(pend_o) - 1'b1));

  p_overdue_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overdue_o |-> req_o);

  p_pay_lowers_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_go_i && req_o && !tick) |=> (pend_o == $past(pend_o) - 1'b1));

endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
  import bank_tracker_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int CLK_PS      = 3750,
  parameter int TRCD_PS     = 15000,
  parameter int TRP_PS      = 15000,
  parameter int TRC_PS      = 55000,
  parameter int REFI_PS     = 7800000,
  parameter int REFI_HOT_PS = 3900000,
  parameter int MAX_PEND    = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [2:0]                          cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0]        bank_i,
  input  logic                                hot_i,
  output logic [NUM_BANKS-1:0]                bank_open_o,
  output logic [NUM_BANKS-1:0]                act_ok_o,
  output logic [NUM_BANKS-1:0]                rw_ok_o,
  output logic                                ref_ok_o,
  output logic                                ref_req_o,
  output logic                                ref_overdue_o,
  output logic [$clog2(MAX_PEND+1)-1:0]       ref_pending_o,
  output logic                                proto_err_o
);
  localparam int BW       = $clog2(NUM_BANKS);
  localparam int TRCD_CYC = ps_to_cyc(TRCD_PS, CLK_PS);
  localparam int TRP_CYC  = ps_to_cyc(TRP_PS, CLK_PS);
  localparam int TRC_CYC  = ps_to_cyc(TRC_PS, CLK_PS);
  localparam int NORM_CYC = ps_to_cyc(REFI_PS, CLK_PS);
  localparam int HOT_CYC  = ps_to_cyc(REFI_HOT_PS, CLK_PS);

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] act_go, pre_go, idle;
  logic                 ref_go;
  logic                 bad_cmd;
  logic                 err_q;

  assign cmd = cmd_e'(cmd_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel       = (bank_i == BW'(b));
    assign act_go[b] = (cmd == CMD_ACT) && sel && act_ok_o[b];
    assign pre_go[b] = (cmd == CMD_PRE) && sel;

    bank_timer #(
      .TRCD_CYC(TRCD_CYC), .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC)
    ) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .act_i(act_go[b]), .pre_i(pre_go[b]),
      .open_o(bank_open_o[b]), .act_ok_o(act_ok_o[b]),
      .rw_ok_o(rw_ok_o[b]), .idle_o(idle[b]));
  end

  assign ref_ok_o = &idle;
  assign ref_go   = (cmd == CMD_REF) && ref_ok_o;

  always_comb begin
    bad_cmd = 1'b0;
    case (cmd)
      CMD_ACT:        bad_cmd = !act_ok_o[bank_i];
      CMD_RD, CMD_WR: bad_cmd = !rw_ok_o[bank_i];
      CMD_REF:        bad_cmd = !ref_ok_o;
      default:        bad_cmd = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (bad_cmd) err_q <= 1'b1;
  end

  assign proto_err_o = err_q;

  refresh_pacer #(
    .NORM_CYC(NORM_CYC), .HOT_CYC(HOT_CYC), .MAX_PEND(MAX_PEND)
  ) u_pacer (
    .clk_i(clk_i), .rst_ni(rst_ni), .hot_i(hot_i), .ref_go_i(ref_go),
    .pend_o(ref_pending_o), .req_o(ref_req_o), .overdue_o(ref_overdue_o));

  p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);

  p_bad_act_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && !act_ok_o[bank_i]) |=> (proto_err_o && $stable(bank_open_o)));

  p_bad_rw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == 3'd2 || cmd_i == 3'd3) && !rw_ok_o[bank_i]) |=> proto_err_o);

  p_ref_closed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ok_o |-> (bank_open_o == '0));

  p_one_open_change_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bank_open_o ^ $past(bank_open_o)) <= 1);

endmodule

// File: tb/bank_tracker_test.sv
`timescale 1ns/1ps
module bank_tracker_test;
  localparam int TRCD = 4, TRP = 4, TRC = 15, NORM = 40, HOT = 20, MAXP = 8;

  logic       clk = 0, rst_ni = 0;
  logic [2:0] cmd_i = 0;
  logic [1:0] bank_i = 0;
  logic       hot_i = 0;
  logic [3:0] bank_open_o, act_ok_o, rw_ok_o, ref_pending_o;
  logic       ref_ok_o, ref_req_o, ref_overdue_o, proto_err_o;

  bank_tracker #(.REFI_PS(150000), .REFI_HOT_PS(75000)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .bank_i(bank_i), .hot_i(hot_i),
    .bank_open_o(bank_open_o), .act_ok_o(act_ok_o), .rw_ok_o(rw_ok_o),
    .ref_ok_o(ref_ok_o), .ref_req_o(ref_req_o), .ref_overdue_o(ref_overdue_o),
    .ref_pending_o(ref_pending_o), .proto_err_o(proto_err_o));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int m_open[4], m_rcd[4], m_rp[4], m_rc[4];
  int m_pend, m_tmr, m_err;

  initial begin
    #(10ns * 150000);
    total++; bad++;
    $display("FAIL watchdog: run hung act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit e_act(int b); return !m_open[b] && m_rp[b] == 0 && m_rc[b] == 0; endfunction
  function automatic bit e_rw(int b);  return m_open[b] && m_rcd[b] == 0; endfunction
  function automatic bit e_ref();
    for (int b = 0; b < 4; b++) if (m_open[b] || m_rp[b] != 0) return 0;
    return 1;
  endfunction
  function automatic bit legal(int c, int b);
    case (c)
      1: return e_act(b);
      2, 3: return e_rw(b);
      5: return e_ref();
      default: return 1;
    endcase
  endfunction

  task automatic compare_all();
    for (int b = 0; b < 4; b++) begin
      chk(bank_open_o[b] == m_open[b][0], "R1 bank_open", bank_open_o[b], m_open[b]);
      chk(act_ok_o[b] == e_act(b), "R3/R4 act_ok", act_ok_o[b], e_act(b));
      chk(rw_ok_o[b] == e_rw(b), "R2 rw_ok", rw_ok_o[b], e_rw(b));
    end
    chk(ref_ok_o == e_ref(), "R6 ref_ok", ref_ok_o, e_ref());
    chk(int'(ref_pending_o) == m_pend, "R7 pending", ref_pending_o, m_pend);
    chk(ref_req_o == (m_pend != 0), "R8 ref_req", ref_req_o, m_pend != 0);
    chk(ref_overdue_o == (m_pend >= MAXP), "R9 overdue", ref_overdue_o, m_pend >= MAXP);
    chk(proto_err_o == m_err[0], "R5 proto_err", proto_err_o, m_err);
  endtask

  task automatic do_reset();
    rst_ni = 0; cmd_i = 0; hot_i = 0;
    @(negedge clk); @(negedge clk);
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_rcd[b] = 0; m_rp[b] = 0; m_rc[b] = 0; end
    m_pend = 0; m_tmr = 0; m_err = 0;
    rst_ni = 1;
    chk(bank_open_o == 4'h0 && act_ok_o == 4'hf && rw_ok_o == 4'h0, "R10 banks", {bank_open_o, act_ok_o, rw_ok_o}, 12'h0f0);
    chk(ref_ok_o && ref_pending_o == 0 && !proto_err_o, "R10 refresh/err", {ref_ok_o, ref_pending_o, proto_err_o}, 6'h20);
  endtask

  task automatic step(input int c, input int b, input bit h);
    bit ok, acc, tick;
    int lim;
    cmd_i = 3'(c); bank_i = 2'(b); hot_i = h;
    ok  = legal(c, b);
    acc = (c == 5) && ok;
    lim = h ? HOT : NORM;
    tick = (m_tmr >= lim - 1);
    m_tmr = tick ? 0 : m_tmr + 1;
    for (int k = 0; k < 4; k++) begin
      if (m_rcd[k] > 0) m_rcd[k]--;
      if (m_rp[k] > 0) m_rp[k]--;
      if (m_rc[k] > 0) m_rc[k]--;
    end
    if (!ok) m_err = 1;
    else if (c == 1) begin m_open[b] = 1; m_rcd[b] = TRCD - 1; m_rc[b] = TRC - 1; end
    else if (c == 4 && m_open[b] != 0) begin m_open[b] = 0; m_rp[b] = TRP - 1; end
    begin
      int pay = (acc && m_pend != 0) ? 1 : 0;
      m_pend = m_pend + (tick ? 1 : 0) - pay;
      if (m_pend > MAXP) m_pend = MAXP;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();

    // R2: read becomes legal exactly TRCD edges after activate
    step(1, 0, 0);
    step(0, 0, 0); step(0, 0, 0);
    chk(rw_ok_o[0] == 0, "R2 early", rw_ok_o[0], 0);
    step(0, 0, 0);
    chk(rw_ok_o[0] == 1, "R2 on time", rw_ok_o[0], 1);
    chk(proto_err_o == 0, "R1 other banks untouched", proto_err_o, 0);
    // R1: precharge of a closed bank does nothing
    step(4, 2, 0);
    chk(act_ok_o[2] == 1 && bank_open_o[2] == 0, "R1 pre closed", act_ok_o[2], 1);
    // R3: activate blocked by precharge recovery
    step(4, 0, 0);
    chk(act_ok_o[0] == 0, "R3/R4 blocked after pre", act_ok_o[0], 0);
    // R5: refused activate keeps the bank closed
    step(1, 0, 0);
    chk(proto_err_o == 1 && bank_open_o[0] == 0, "R5 refused act", {proto_err_o, bank_open_o[0]}, 2);
    step(0, 0, 0);
    chk(proto_err_o == 1, "R5 sticky", proto_err_o, 1);

    // R5: read on a closed bank
    do_reset();
    step(2, 3, 0);
    chk(proto_err_o == 1 && rw_ok_o[3] == 0, "R5 read closed", proto_err_o, 1);

    // R7/R9: hot interval, then run to saturation
    do_reset();
    for (int i = 0; i < HOT - 1; i++) step(0, 0, 1);
    chk(ref_pending_o == 0, "R7 hot before end", ref_pending_o, 0);
    step(0, 0, 1);
    chk(ref_pending_o == 1, "R7 hot interval", ref_pending_o, 1);
    for (int i = 0; i < NORM * 9; i++) step(0, 0, 0);
    chk(ref_overdue_o == 1 && ref_pending_o == MAXP, "R9 saturate", ref_pending_o, MAXP);
    step(5, 0, 0);
    chk(ref_pending_o == MAXP - 1 && ref_overdue_o == 0, "R8 refresh pays", ref_pending_o, MAXP - 1);
    // R6: refresh refused while a bank is open
    step(1, 1, 0);
    step(5, 0, 0);
    chk(proto_err_o == 1 && ref_ok_o == 0, "R6 ref with open bank", proto_err_o, 1);

    // random segments, mostly legal commands
    for (int seg = 0; seg < 8; seg++) begin
      bit h = 0;
      do_reset();
      for (int n = 0; n < 2000; n++) begin
        int c = 0, b = 0;
        if ($urandom_range(0, 199) == 0) h = ~h;
        if (m_pend > 0 && e_ref() && $urandom_range(0, 3) == 0) c = 5;
        else if ($urandom_range(0, 63) == 0 && seg > 1) begin
          c = $urandom_range(0, 7); b = $urandom_range(0, 3);
        end else begin
          for (int k = 0; k < 6; k++) begin
            c = $urandom_range(0, 5); b = $urandom_range(0, 3);
            if (legal(c, b)) break;
            c = 0;
          end
        end
        step(c, b, h);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule